// File: doc/BRIEF.md
# Outer-Product Update Pulse Sequencer

This controller produces the switch timing for one parallel weight update on a small analog crossbar. Each row has one switch enable and each column has one switch enable. A cell changes only while both of its enables are high, so the change applied to it follows from how long the two pulses overlap. The controller receives a binary input vector, one signed error per column, a learning-rate scale and a rounding mode. From these it drives row enables for a fixed width, column enables for widths derived from the errors, and a shared write-polarity select.

The array shares one polarity line, so increases and decreases cannot run at the same time. The update therefore runs as a series of polarity phases, and each phase pulses only the rows and columns whose signs match it. A separate read operation opens a fixed window on the selected rows while every switch stays open. All timing is counted in ticks of an external 1 ms tick-enable. A host starts an operation with `start_i` and waits for `done_o`.

Top module: `outer_update_seq`

## Requirements
- R1: While `rst_ni` is low and after it rises, every row and column enable, `read_o`, `busy_o` and `done_o` are low, and `pol_o` is 2'b00 (idle).
- R2: In each phase that runs, a row whose input bit is 1 (and whose sign matches the phase) is enabled for exactly UNIT_TICKS (10) ticks. A row whose input bit is 0 is never enabled.
- R3: In continuous mode (`disc_i`=0), errors are signed Q4.8 with 12 bits per column, column c at bits [12c+11:12c], and alpha is unsigned Q4.8. A column is enabled for round(|alpha·err|·10) ticks, with halves rounded up, and the width is capped at 255 ticks.
- R4: In discrete mode (`disc_i`=1), an error with |err| ≥ 0.5 counts as ±1 and any smaller error counts as 0. The column is then enabled for round(alpha·10) ticks or not at all, capped at 255.
- R5: With unsigned inputs (`sgn_i`=0), the increase phase runs first with `pol_o`=2'b10, the negative write polarity. It pulses the columns with err>0. The decrease phase runs next with `pol_o`=2'b01 and pulses the columns with err<0. `pol_o` is one-hot or zero.
- R6: The row and column pulses of a phase rise in the same cycle, so each cell's change equals the smaller of its two widths.
- R7: A phase with no enabled row or no nonzero column in its sign group takes no time. When no phase qualifies, `done_o` is high on the second cycle after the start is accepted.
- R8: `pol_o` changes only after all enables have been low for at least one tick. Enables rise only after at least one tick has been seen with the new polarity.
- R9: With signed inputs (`sgn_i`=1, where `xneg_i[r]` marks a negative input), up to four phases run in this order: (x+,e+) increase, (x+,e−) decrease, (x−,e+) decrease, (x−,e−) increase.
- R10: A read (`read_i`=1) drives `read_o` equal to the input bits for READ_TICKS (10) ticks. During a read, all enables stay low and `pol_o` stays idle.
- R11: `start_i` is accepted only when `busy_o` is low, and a start seen while busy has no effect. Each operation ends with a `done_o` pulse one cycle wide, and the block is quiet while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base enable, one per millisecond |
| start_i | input | 1 | Starts an operation when idle |
| read_i | input | 1 | 1: read window, 0: weight update |
| disc_i | input | 1 | 1: errors rounded to −1/0/+1 |
| sgn_i | input | 1 | 1: input signs taken from xneg_i |
| x_i | input | N_ROWS | Binary input vector |
| xneg_i | input | N_ROWS | Per-row negative-input flag |
| err_i | input | N_COLS*ERR_W | Packed signed Q4.8 column errors |
| alpha_i | input | ALPHA_W | Unsigned Q4.8 learning-rate scale |
| row_en_o | output | N_ROWS | Row switch enables |
| col_en_o | output | N_COLS | Column switch enables |
| pol_o | output | 2 | Write polarity: 00 idle, 01 positive (decrease), 10 negative (increase) |
| read_o | output | N_ROWS | Read window per row |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default build: a 3×3 array, 12-bit Q4.8 errors and alpha, a 10-tick unit, a 10-tick read and a 255-tick cap. It supplies a tick every four clocks. With these sizes, all eight row patterns and all 64 input-sign combinations can be swept, and a full-scale alpha and error reach the 255-tick cap. The bench integrates the signed overlap of every row and column pair, tick by tick, and compares it with an outer product computed from the formulas in the requirements. It also checks the phase order, the polarity guard intervals and the latency of a skipped operation.

// File: rtl/outer_update_pkg.sv
package outer_update_pkg;

  typedef enum logic [1:0] {
    POL_IDLE = 2'b00,
    POL_DEC  = 2'b01,  // positive write voltage
    POL_INC  = 2'b10   // negative write voltage
  } pol_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_ARM,
    ST_PULSE,
    ST_HOLD,
    ST_READ,
    ST_DONE
  } st_e;

  // phase index: bit1 = input negative, bit0 = error negative
  function automatic pol_e phase_pol(input logic [1:0] ph);
    return (ph[0] == ph[1]) ? POL_INC : POL_DEC;
  endfunction

endpackage

// File: rtl/oup_col_width.sv
module oup_col_width #(
  parameter int ERR_W      = 12,
  parameter int ALPHA_W    = 12,
  parameter int FRAC       = 8,
  parameter int UNIT_TICKS = 10,
  parameter int MAX_TICKS  = 255,
  parameter int W_W        = 8
) (
  input  logic [ERR_W-1:0]   err_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  input  logic               disc_i,
  output logic [W_W-1:0]     width_o,
  output logic               neg_o
);
  localparam int PW = ALPHA_W + ERR_W + 9;

  logic [ERR_W:0] mag;
  logic [PW-1:0]  prod, scaled, aw, raw;

  always_comb begin
    mag    = err_i[ERR_W-1] ? (ERR_W+1)'(-$signed({err_i[ERR_W-1], err_i}))
                            : {1'b0, err_i};
    prod   = PW'(alpha_i) * PW'(mag);
    scaled = prod * PW'(UNIT_TICKS) + (PW'(1) << (2*FRAC-1));
    aw     = (PW'(alpha_i) * PW'(UNIT_TICKS) + (PW'(1) << (FRAC-1))) >> FRAC;
    if (disc_i)
      raw = (mag >= (ERR_W+1)'(1 << (FRAC-1))) ? aw : '0;
    else
      raw = scaled >> (2*FRAC);
    width_o = (raw > PW'(MAX_TICKS)) ? W_W'(MAX_TICKS) : raw[W_W-1:0];
    neg_o   = err_i[ERR_W-1];
  end

endmodule

// File: rtl/oup_phase_plan.sv
module oup_phase_plan #(
  parameter int N_ROWS     = 3,
  parameter int N_COLS     = 3,
  parameter int W_W        = 8,
  parameter int UNIT_TICKS = 10
) (
  input  logic [N_ROWS-1:0]             x_i,
  input  logic [N_ROWS-1:0]             xneg_i,
  input  logic                          sgn_i,
  input  logic [N_COLS-1:0][W_W-1:0]    width_i,
  input  logic [N_COLS-1:0]             neg_i,
  output logic [3:0][N_ROWS-1:0]        row_m_o,
  output logic [3:0][N_COLS-1:0]        col_m_o,
  output logic [3:0][W_W-1:0]           span_o,
  output logic [3:0]                    live_o
);
  for (genvar p = 0; p < 4; p++) begin : g_ph
    localparam bit X_NEG = (p >= 2);
    localparam bit E_NEG = ((p % 2) == 1);

    logic [N_ROWS-1:0] rm;
    logic [N_COLS-1:0] cm;
    logic [W_W-1:0]    sp;

    always_comb begin
      if (sgn_i) rm = X_NEG ? (x_i & xneg_i) : (x_i & ~xneg_i);
      else       rm = X_NEG ? '0 : x_i;
      sp = W_W'(UNIT_TICKS);
      for (int c = 0; c < N_COLS; c++) begin
        cm[c] = (width_i[c] != '0) && (neg_i[c] == E_NEG);
        if (cm[c] && (width_i[c] > sp)) sp = width_i[c];
      end
    end

    assign row_m_o[p] = rm;
    assign col_m_o[p] = cm;
    assign span_o[p]  = sp;
    assign live_o[p]  = (|rm) && (|cm);
  end

endmodule

// File: rtl/outer_update_seq.sv
module outer_update_seq
  import outer_update_pkg::*;
#(
  parameter int N_ROWS     = 3,
  parameter int N_COLS     = 3,
  parameter int ERR_W      = 12,
  parameter int ALPHA_W    = 12,
  parameter int FRAC       = 8,
  parameter int UNIT_TICKS = 10,
  parameter int READ_TICKS = 10,
  parameter int MAX_TICKS  = 255
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      start_i,
  input  logic                      read_i,
  input  logic                      disc_i,
  input  logic                      sgn_i,
  input  logic [N_ROWS-1:0]         x_i,
  input  logic [N_ROWS-1:0]         xneg_i,
  input  logic [N_COLS*ERR_W-1:0]   err_i,
  input  logic [ALPHA_W-1:0]        alpha_i,
  output logic [N_ROWS-1:0]         row_en_o,
  output logic [N_COLS-1:0]         col_en_o,
  output logic [1:0]                pol_o,
  output logic [N_ROWS-1:0]         read_o,
  output logic                      busy_o,
  output logic                      done_o
);
  localparam int W_W     = $clog2(MAX_TICKS + 1);
  localparam int CNT_MAX = (MAX_TICKS > READ_TICKS) ? MAX_TICKS : READ_TICKS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  st_e                     st_q;
  logic [1:0]              ph_q;
  logic [CW-1:0]           cnt_q, cnt_nx;
  logic [N_ROWS-1:0]       x_q, xn_q;
  logic                    sgn_q, disc_q;
  logic [N_COLS*ERR_W-1:0] err_q;
  logic [ALPHA_W-1:0]      alpha_q;

  logic [N_COLS-1:0][W_W-1:0] width;
  logic [N_COLS-1:0]          cneg;
  logic [3:0][N_ROWS-1:0]     row_m;
  logic [3:0][N_COLS-1:0]     col_m;
  logic [3:0][W_W-1:0]        span;
  logic [3:0]                 live;
  logic                       nxt_ok;
  logic [1:0]                 nxt_ph;
  logic                       span_end, read_end;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    oup_col_width #(
      .ERR_W(ERR_W), .ALPHA_W(ALPHA_W), .FRAC(FRAC),
      .UNIT_TICKS(UNIT_TICKS), .MAX_TICKS(MAX_TICKS), .W_W(W_W)
    ) u_w (
      .err_i   (err_q[c*ERR_W +: ERR_W]),
      .alpha_i (alpha_q),
      .disc_i  (disc_q),
      .width_o (width[c]),
      .neg_o   (cneg[c])
    );
  end

  oup_phase_plan #(
    .N_ROWS(N_ROWS), .N_COLS(N_COLS), .W_W(W_W), .UNIT_TICKS(UNIT_TICKS)
  ) u_plan (
    .x_i     (x_q),
    .xneg_i  (xn_q),
    .sgn_i   (sgn_q),
    .width_i (width),
    .neg_i   (cneg),
    .row_m_o (row_m),
    .col_m_o (col_m),
    .span_o  (span),
    .live_o  (live)
  );

  // lowest live phase above the current one (any, when planning)
  always_comb begin
    nxt_ok = 1'b0;
    nxt_ph = '0;
    for (int p = 3; p >= 0; p--) begin
      if (live[p] && ((st_q == ST_PLAN) || (p > int'(ph_q)))) begin
        nxt_ok = 1'b1;
        nxt_ph = 2'(p);
      end
    end
  end

  assign cnt_nx   = cnt_q + 1'b1;
  assign span_end = (cnt_nx == CW'(span[ph_q]));
  assign read_end = (cnt_nx == CW'(READ_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= '0;
      cnt_q   <= '0;
      x_q     <= '0;
      xn_q    <= '0;
      sgn_q   <= 1'b0;
      disc_q  <= 1'b0;
      err_q   <= '0;
      alpha_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          x_q     <= x_i;
          xn_q    <= xneg_i;
          sgn_q   <= sgn_i;
          disc_q  <= disc_i;
          err_q   <= err_i;
          alpha_q <= alpha_i;
          cnt_q   <= '0;
          st_q    <= read_i ? ST_READ : ST_PLAN;
        end
        ST_PLAN: begin
          ph_q <= nxt_ph;
          st_q <= nxt_ok ? ST_ARM : ST_DONE;
        end
        ST_ARM: if (tick_i) begin
          cnt_q <= '0;
          st_q  <= ST_PULSE;
        end
        ST_PULSE: if (tick_i) begin
          if (span_end) begin
            cnt_q <= '0;
            st_q  <= ST_HOLD;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
        ST_HOLD: if (tick_i) begin
          ph_q <= nxt_ok ? nxt_ph : ph_q;
          st_q <= nxt_ok ? ST_ARM : ST_DONE;
        end
        ST_READ: if (tick_i) begin
          if (read_end) st_q <= ST_DONE;
          else          cnt_q <= cnt_nx;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pol_o    = POL_IDLE;
    row_en_o = '0;
    col_en_o = '0;
    if ((st_q == ST_ARM) || (st_q == ST_PULSE) || (st_q == ST_HOLD))
      pol_o = phase_pol(ph_q);
    if (st_q == ST_PULSE) begin
      if (cnt_q < CW'(UNIT_TICKS)) row_en_o = row_m[ph_q];
      for (int c = 0; c < N_COLS; c++)
        col_en_o[c] = col_m[ph_q][c] && (cnt_q < CW'(width[c]));
    end
  end

  assign read_o = (st_q == ST_READ) ? x_q : '0;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_DONE);

endmodule

// File: rtl/outer_update_seq_chk.sv
module outer_update_seq_chk #(
  parameter int N_ROWS     = 3,
  parameter int N_COLS     = 3,
  parameter int UNIT_TICKS = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [N_ROWS-1:0] row_en_o,
  input logic [N_COLS-1:0] col_en_o,
  input logic [1:0]        pol_o,
  input logic [N_ROWS-1:0] read_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int RW = $clog2(UNIT_TICKS + 1);

  logic [RW-1:0] row_tk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              row_tk_q <= '0;
    else if (row_en_o == '0)  row_tk_q <= '0;
    else if (tick_i)          row_tk_q <= row_tk_q + 1'b1;
  end

  AST_ROW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_en_o != '0) |-> (row_tk_q < RW'(UNIT_TICKS))); // R2

  AST_POL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pol_o)); // R5

  AST_COL_WITH_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((col_en_o & ~$past(col_en_o)) != '0) |-> ((row_en_o != '0) && ($past(row_en_o) == '0))); // R6

  AST_EN_NEEDS_POL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_en_o != '0) || (col_en_o != '0)) |-> (pol_o != 2'b00)); // R8

  AST_POL_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_o != $past(pol_o)) |-> ((row_en_o == '0) && (col_en_o == '0) &&
                                 ($past(row_en_o) == '0) && ($past(col_en_o) == '0))); // R8

  AST_READ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_o != '0) |-> ((row_en_o == '0) && (col_en_o == '0) && (pol_o == 2'b00))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ((row_en_o == '0) && (col_en_o == '0) && (pol_o == 2'b00) &&
                 (read_o == '0) && !done_o)); // R11

endmodule

bind outer_update_seq outer_update_seq_chk #(
  .N_ROWS(N_ROWS), .N_COLS(N_COLS), .UNIT_TICKS(UNIT_TICKS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .row_en_o (row_en_o),
  .col_en_o (col_en_o),
  .pol_o    (pol_o),
  .read_o   (read_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/tb_outer_update_seq.sv
module tb_outer_update_seq;
  localparam int NR = 3, NC = 3, EW = 12, AW = 12;
  localparam int UNIT = 10, RD = 10, MAXW = 255, TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, start_i = 1'b0, read_i = 1'b0, disc_i = 1'b0, sgn_i = 1'b0;
  logic [NR-1:0] x_i = '0, xneg_i = '0;
  logic [NC*EW-1:0] err_i = '0;
  logic [AW-1:0] alpha_i = '0;
  logic [NR-1:0] row_en_o, read_o;
  logic [NC-1:0] col_en_o;
  logic [1:0] pol_o;
  logic busy_o, done_o;

  int n_chk = 0, n_bad = 0;

  outer_update_seq #(
    .N_ROWS(NR), .N_COLS(NC), .ERR_W(EW), .ALPHA_W(AW), .FRAC(8),
    .UNIT_TICKS(UNIT), .READ_TICKS(RD), .MAX_TICKS(MAXW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .start_i(start_i),
    .read_i(read_i), .disc_i(disc_i), .sgn_i(sgn_i), .x_i(x_i),
    .xneg_i(xneg_i), .err_i(err_i), .alpha_i(alpha_i),
    .row_en_o(row_en_o), .col_en_o(col_en_o), .pol_o(pol_o),
    .read_o(read_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  initial begin
    int tdiv = 0;
    forever begin
      @(posedge clk); #1;
      tdiv   = (tdiv == TDIV-1) ? 0 : tdiv + 1;
      tick_i = (tdiv == 0);
    end
  end

  // monitor: integrates overlap per cell, ticks per line, phase order, guards
  int dw [NR][NC];
  int col_tk [NC];
  int row_tk [NR];
  int rd_tk [NR];
  int seq, nseg, n_done, guard_bad, read_bad;
  int low_tk = 1, pol_tk = 1;
  logic [1:0] prev_pol = 2'b00;
  logic prev_any = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic any;
      any = (row_en_o != '0) || (col_en_o != '0);
      if (pol_o != prev_pol && (any || low_tk < 1)) guard_bad++;
      if (pol_o != prev_pol) pol_tk = 0;
      if (pol_o == 2'b11) guard_bad++;
      if (any && !prev_any) begin
        if (pol_tk < 1) guard_bad++;
        seq = seq * 4 + int'(pol_o);
        nseg++;
      end
      if (read_o != '0 && (any || pol_o != 2'b00)) read_bad++;
      if (done_o) n_done++;
      if (tick_i) begin
        for (int r = 0; r < NR; r++) begin
          if (row_en_o[r]) row_tk[r]++;
          if (read_o[r]) rd_tk[r]++;
          for (int c = 0; c < NC; c++)
            if (row_en_o[r] && col_en_o[c])
              dw[r][c] += (pol_o == 2'b10) ? 1 : ((pol_o == 2'b01) ? -1 : 1000);
        end
        for (int c = 0; c < NC; c++) if (col_en_o[c]) col_tk[c]++;
        pol_tk++;
      end
      if (any) low_tk = 0;
      else if (tick_i) low_tk++;
      prev_pol = pol_o;
      prev_any = any;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_w(input int e, input int a, input bit ds);
    longint m, r;
    m = (e < 0) ? -e : e;
    if (ds) r = (m >= 128) ? ((longint'(a) * UNIT + 128) >>> 8) : 0;
    else    r = (longint'(a) * m * UNIT + 32768) >>> 16;
    if (r > MAXW) r = MAXW;
    return int'(r);
  endfunction

  task automatic clear_mon();
    for (int r = 0; r < NR; r++) begin
      row_tk[r] = 0; rd_tk[r] = 0;
      for (int c = 0; c < NC; c++) dw[r][c] = 0;
    end
    for (int c = 0; c < NC; c++) col_tk[c] = 0;
    seq = 0; nseg = 0; n_done = 0; guard_bad = 0; read_bad = 0;
  endtask

  task automatic run_op(input bit rd, input logic [NR-1:0] x, input logic [NR-1:0] xn,
                        input bit sg, input bit ds, input int a,
                        input int e0, input int e1, input int e2, input bit poke);
    int ev [NC];
    int w [NC];
    int edw [NR][NC];
    int ecol [NC];
    int erow [NR];
    int eseq, nlive, lat;
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    @(posedge clk); #1;
    clear_mon();
    read_i = rd; x_i = x; xneg_i = xn; sgn_i = sg; disc_i = ds;
    alpha_i = AW'(a);
    for (int c = 0; c < NC; c++) err_i[c*EW +: EW] = ev[c][EW-1:0];
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (poke && lat == 20) begin
        start_i = 1'b1; read_i = ~rd; x_i = ~x; err_i = ~err_i;
      end
      if (poke && lat == 21) begin
        start_i = 1'b0; read_i = rd; x_i = x;
        for (int c = 0; c < NC; c++) err_i[c*EW +: EW] = ev[c][EW-1:0];
      end
    end while (!done_o && lat < 20000);
    repeat (3) @(negedge clk);
    chk("R11", "done pulses", n_done, 1);
    if (rd) begin
      for (int r = 0; r < NR; r++) chk("R10", "read window ticks", rd_tk[r], x[r] ? RD : 0);
      chk("R10", "pulses during read", nseg, 0);
      chk("R10", "enables/polarity during read", read_bad, 0);
      return;
    end
    for (int c = 0; c < NC; c++) begin w[c] = exp_w(ev[c], a, ds); ecol[c] = 0; end
    for (int r = 0; r < NR; r++) begin
      erow[r] = 0;
      for (int c = 0; c < NC; c++) edw[r][c] = 0;
    end
    eseq = 0; nlive = 0;
    for (int p = 0; p < 4; p++) begin
      bit xneg_ph, eneg, inc, anyr, anyc;
      bit rm [NR];
      bit cm [NC];
      xneg_ph = (p >= 2); eneg = (p % 2 == 1); inc = (p == 0 || p == 3);
      anyr = 0; anyc = 0;
      for (int r = 0; r < NR; r++) begin
        rm[r] = x[r] && (sg ? (xn[r] == xneg_ph) : !xneg_ph);
        anyr |= rm[r];
      end
      for (int c = 0; c < NC; c++) begin
        cm[c] = (w[c] != 0) && ((ev[c] < 0) == eneg);
        anyc |= cm[c];
      end
      if (anyr && anyc) begin
        eseq = eseq * 4 + (inc ? 2 : 1);
        nlive++;
        for (int r = 0; r < NR; r++) if (rm[r]) erow[r] += UNIT;
        for (int c = 0; c < NC; c++) if (cm[c]) ecol[c] += w[c];
        for (int r = 0; r < NR; r++)
          for (int c = 0; c < NC; c++)
            if (rm[r] && cm[c])
              edw[r][c] += (inc ? 1 : -1) * ((w[c] < UNIT) ? w[c] : UNIT);
      end
    end
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        chk(ds ? "R4 R6" : "R3 R6", "cell overlap", dw[r][c], edw[r][c]);
    for (int c = 0; c < NC; c++) chk(ds ? "R4" : "R3", "column ticks", col_tk[c], ecol[c]);
    for (int r = 0; r < NR; r++) chk("R2", "row ticks", row_tk[r], erow[r]);
    chk(sg ? "R9" : "R5", "phase polarity order", seq, eseq);
    chk("R8", "polarity guard", guard_bad, 0);
    if (nlive == 0) begin
      chk("R7", "skip latency", lat, 2);
      chk("R7", "pulses when skipped", nseg, 0);
    end
    if (poke) begin
      int rs;
      rs = 0;
      for (int r = 0; r < NR; r++) rs += rd_tk[r];
      chk("R11", "start while busy read ticks", rs, 0);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int dlist [7];
    dlist[0] = -300; dlist[1] = -128; dlist[2] = -127; dlist[3] = 0;
    dlist[4] = 127;  dlist[5] = 128;  dlist[6] = 2047;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset",
        int'({row_en_o, col_en_o, pol_o, read_o, busy_o, done_o}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs after reset",
        int'({row_en_o, col_en_o, pol_o, read_o, busy_o, done_o}), 0);

    // R3 continuous sweep at alpha 1.0
    for (int i = 0; i < 25; i++)
      run_op(0, 3'b111, 3'b000, 0, 0, 256, -1200 + i*100, 1200 - i*97, i*37 - 300, 0);
    // R3 alpha sweep and cap
    for (int k = 0; k < 8; k++)
      run_op(0, 3'b101, 3'b000, 0, 0, k*585, 700, -333, 2047, 0);
    run_op(0, 3'b111, 3'b000, 0, 0, 4095, -2048, 5, 1, 0);
    // R4 discrete rounding
    for (int i = 0; i < 7; i++) begin
      run_op(0, 3'b111, 3'b000, 0, 1, 256, dlist[i], dlist[(i+3)%7], dlist[(i+5)%7], 0);
      run_op(0, 3'b011, 3'b000, 0, 1, 640, dlist[i], dlist[(i+2)%7], dlist[(i+4)%7], 0);
    end
    // R2 R5 R7 all row patterns
    for (int x = 0; x < 8; x++)
      run_op(0, 3'(x), 3'b000, 0, 0, 256, 300, -500, 0, 0);
    // R9 all input sign combinations
    for (int x = 0; x < 8; x++)
      for (int n = 0; n < 8; n++)
        run_op(0, 3'(x), 3'(n), 1, 0, 256, 256, -128, 64, 0);
    run_op(0, 3'b111, 3'b010, 1, 1, 256, -200, 200, 0, 0);
    // R7 nothing to do
    run_op(0, 3'b111, 3'b000, 0, 0, 256, 0, 0, 0, 0);
    run_op(0, 3'b111, 3'b000, 0, 0, 256, 12, -12, 0, 0);
    // R10 read windows
    for (int x = 0; x < 8; x++)
      run_op(1, 3'(x), 3'b000, 0, 0, 256, 500, -500, 500, 0);
    // R11 start while busy
    run_op(0, 3'b110, 3'b000, 0, 0, 256, 400, -400, 100, 1);
    run_op(1, 3'b011, 3'b000, 0, 0, 256, 400, -400, 100, 1);

    summary();
    $finish;
  end

endmodule